// File: doc/BRIEF.md
# Receive Descriptor Writer

This block is the hardware half of a receive descriptor ring. A local store holds `DESC_NUM` descriptors of two 32-bit words each. The even word carries the buffer address together with two control bits. The odd word carries the completion status. Software prepares and releases descriptors through a word-wide memory port. When a finished frame is reported on the frame stream, the engine walks the ring from its current position. It writes the frame length and the frame boundary flags into each descriptor it fills, then sets the ownership bit to hand that descriptor back to software.

A frame longer than `BUF_BYTES` is spread over as many consecutive descriptors as it needs. If the engine meets a descriptor that software has not yet released, the rest of the frame is discarded and a one-cycle no-buffer pulse is raised. The ring restarts at a software-chosen base index, either after a descriptor carrying the wrap bit or after the last physical descriptor.

The frame stream is valid/ready. `frm_valid` must stay high until it is accepted, and `frm_len` is sampled only in the cycle where `frm_valid` and `frm_ready` are both high. `frm_ready` stays low while a frame is being recorded, which back-pressures the next frame.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset `frm_ready` is 1, `nobuf` is 0 and every descriptor word reads as 0.
- R2: A frame is taken only on `frm_valid && frm_ready`. `frm_ready` is 0 in the cycle that follows the acceptance and stays 0 until the frame is recorded, and `frm_len` changes during that time have no effect.
- R3: The status word written by the engine is: bits 13:0 the byte count placed in that descriptor, bit 14 set on the frame's first descriptor, bit 15 set on its last descriptor, and bits 31:16 zero.
- R4: When the engine fills a descriptor it sets bit 0 (ownership) of the address word and leaves bits 31:1 unchanged.
- R5: A frame of L bytes uses ceil(L/BUF_BYTES) descriptors, with a minimum of one for L=0. Every descriptor holds BUF_BYTES except the last, which holds the remainder.
- R6: After a descriptor whose address-word bit 1 (wrap) is set, the next descriptor used is the ring base.
- R7: After descriptor `DESC_NUM-1` without a wrap bit, the next descriptor used is the ring base.
- R8: If the descriptor needed next has ownership bit 1, that descriptor is left unchanged, the remainder of the frame is dropped, `nobuf` pulses for exactly one cycle, and the ring position stays on that descriptor.
- R9: Writing `base_idx` with `base_we` sets both the ring base and the current position to `base_idx`.
- R10: A software write wins the store in its cycle. A busy engine stalls for that cycle and loses none of its own writes.
- R11: `sw_rdata` returns the word at `sw_addr` one clock after the address is presented. Word `2*i` is the address word and word `2*i+1` is the status word of descriptor i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A finished frame is offered |
| frm_ready | output | 1 | Engine idle, frame can be accepted |
| frm_len | input | 14 | Byte count of the offered frame |
| nobuf | output | 1 | One-cycle pulse: frame (remainder) dropped for lack of a released descriptor |
| base_we | input | 1 | Load the ring base |
| base_idx | input | IDX_W (5) | New ring base descriptor index |
| sw_we | input | 1 | Software word write |
| sw_addr | input | IDX_W+1 (6) | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Registered read data for `sw_addr` |

## Verification
On every cycle, the assertions check the following. An accepted frame lowers `frm_ready`. `nobuf` never lasts two cycles. Engine status writes keep their upper half clear, and engine address-word writes always carry the ownership bit. The ring pointer reloads and wraps as required, and the engine stands still under a software write. Whether the right descriptors hold the right counts and flags can only be shown by the bench scenarios: split frames, drops part-way through a frame, resumption after a release, base changes, and a software write colliding with engine activity. The bench reads the whole affected descriptor state back through the software port and compares it with an independent ring model.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 14;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_WSTAT = 2'd2,
    S_WADDR = 2'd3
  } eng_state_t;
endpackage

// File: rtl/rxdw_store.sv
module rxdw_store
  import rxdw_pkg::*;
#(
  parameter int DESC_NUM = 32,
  localparam int IDX_W = $clog2(DESC_NUM),
  localparam int WA_W  = IDX_W + 1,
  localparam int WORDS = 2 * DESC_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [WA_W-1:0]   sw_addr,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata,
  input  logic              eng_we,
  input  logic [WA_W-1:0]   eng_addr,
  input  logic [WORD_W-1:0] eng_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] desc_word
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      sw_rdata <= '0;
    end else begin
      if (sw_we)       mem[sw_addr]  <= sw_wdata;
      else if (eng_we) mem[eng_addr] <= eng_wdata;
      sw_rdata <= mem[sw_addr];
    end
  end

  assign desc_word = mem[{rd_idx, 1'b0}];

  // R3
  stat_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we && eng_addr[0] |-> eng_wdata[WORD_W-1:16] == '0);

  // R4
  addr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we && !eng_addr[0] |-> eng_wdata[OWN_BIT] && eng_wdata[WORD_W-1:1] == desc_word[WORD_W-1:1]);
endmodule

// File: rtl/rxdw_ring_ptr.sv
module rxdw_ring_ptr #(
  parameter int DESC_NUM = 32,
  localparam int IDX_W = $clog2(DESC_NUM),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_NUM - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             advance,
  input  logic             wrap,
  output logic [IDX_W-1:0] cur
);
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur    <= '0;
    end else if (base_we) begin
      base_q <= base_idx;
      cur    <= base_idx;
    end else if (advance) begin
      cur <= (wrap || cur == LAST) ? base_q : cur + 1'b1;
    end
  end

  // R6
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && wrap && !base_we |=> cur == $past(base_q));

  // R7
  end_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !wrap && cur == LAST && !base_we |=> cur == $past(base_q));

  // R9
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> cur == $past(base_idx));
endmodule

// File: rtl/rxdw_engine.sv
module rxdw_engine
  import rxdw_pkg::*;
#(
  parameter int DESC_NUM  = 32,
  parameter int BUF_BYTES = 1536,
  localparam int IDX_W = $clog2(DESC_NUM),
  localparam int WA_W  = IDX_W + 1,
  localparam logic [LEN_W-1:0] BUF_L = LEN_W'(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              nobuf,
  input  logic              sw_busy,
  input  logic [IDX_W-1:0]  cur,
  input  logic [WORD_W-1:0] desc_word,
  output logic              eng_we,
  output logic [WA_W-1:0]   eng_addr,
  output logic [WORD_W-1:0] eng_wdata,
  output logic              advance
);
  eng_state_t       state;
  logic [LEN_W-1:0] rem;
  logic             first;
  logic             last_chunk;
  logic [LEN_W-1:0] chunk;

  assign last_chunk = (rem <= BUF_L);
  assign chunk      = last_chunk ? rem : BUF_L;
  assign frm_ready  = (state == S_IDLE);
  assign eng_we     = !sw_busy && (state == S_WSTAT || state == S_WADDR);
  assign eng_addr   = {cur, state == S_WSTAT};
  assign advance    = eng_we && (state == S_WADDR);

  always_comb begin
    if (state == S_WSTAT)
      eng_wdata = {(WORD_W-LEN_W-2)'(0), last_chunk, first, chunk};
    else
      eng_wdata = desc_word | WORD_W'(1 << OWN_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rem   <= '0;
      first <= 1'b0;
      nobuf <= 1'b0;
    end else begin
      nobuf <= 1'b0;
      case (state)
        S_IDLE: if (frm_valid) begin
          rem   <= frm_len;
          first <= 1'b1;
          state <= S_CHECK;
        end
        S_CHECK: if (!sw_busy) begin
          if (desc_word[OWN_BIT]) begin
            nobuf <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_WSTAT;
          end
        end
        S_WSTAT: if (!sw_busy) state <= S_WADDR;
        S_WADDR: if (!sw_busy) begin
          rem   <= rem - chunk;
          first <= 1'b0;
          state <= last_chunk ? S_IDLE : S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready |=> !frm_ready);

  // R8
  nobuf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nobuf |=> !nobuf);

  // R10
  sw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_busy && state != S_IDLE |=> state == $past(state) && !$past(eng_we));
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdw_pkg::*;
#(
  parameter int DESC_NUM  = 32,
  parameter int BUF_BYTES = 1536,
  localparam int IDX_W = $clog2(DESC_NUM),
  localparam int WA_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              nobuf,
  input  logic              base_we,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic              sw_we,
  input  logic [WA_W-1:0]   sw_addr,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata
);
  logic [IDX_W-1:0]  cur;
  logic [WORD_W-1:0] desc_word;
  logic              eng_we;
  logic [WA_W-1:0]   eng_addr;
  logic [WORD_W-1:0] eng_wdata;
  logic              advance;

  rxdw_store #(.DESC_NUM(DESC_NUM)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .rd_idx(cur), .desc_word(desc_word)
  );

  rxdw_ring_ptr #(.DESC_NUM(DESC_NUM)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_idx(base_idx),
    .advance(advance), .wrap(desc_word[WRAP_BIT]), .cur(cur)
  );

  rxdw_engine #(.DESC_NUM(DESC_NUM), .BUF_BYTES(BUF_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_len(frm_len), .nobuf(nobuf),
    .sw_busy(sw_we), .cur(cur), .desc_word(desc_word),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata), .advance(advance)
  );
endmodule

// File: tb/rx_desc_writer_test.sv
module rx_desc_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 32;
  localparam int BUFB  = 1536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [13:0] frm_len = '0;
  logic        nobuf;
  logic        base_we = 1'b0;
  logic [4:0]  base_idx = '0;
  logic        sw_we = 1'b0;
  logic [5:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  rx_desc_writer #(.DESC_NUM(NDESC), .BUF_BYTES(BUFB)) uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .nobuf(nobuf), .base_we(base_we), .base_idx(base_idx),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int nb_cnt  = 0;
  int exp_nb  = 0;
  logic [31:0] model [2*NDESC];
  int exp_q [$];
  string tag_q [$];
  int m_cur  = 0;
  int m_base = 0;

  always @(posedge clk) if (rst_n && nobuf) nb_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // R11: read data appears one clock after the address
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk) sw_addr = 6'(a);
    @(negedge clk) d = sw_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk) begin sw_we = 1'b1; sw_addr = 6'(a); sw_wdata = d; end
    @(negedge clk) sw_we = 1'b0;
    model[a] = d;
  endtask

  task automatic setbase(input int i);
    @(negedge clk) begin base_we = 1'b1; base_idx = 5'(i); end
    @(negedge clk) base_we = 1'b0;
    m_base = i;
    m_cur  = i;
  endtask

  // driver: predicts the ring and pushes expected words for the monitor
  task automatic send(input int len, input bit stall, input string tag);
    int rem;
    int chunk;
    bit first;
    rem = len;
    first = 1'b1;
    do begin
      if (model[2*m_cur][0]) begin
        exp_nb++;
        exp_q.push_back(2*m_cur);   tag_q.push_back({tag, " R8 owned addr"});
        exp_q.push_back(2*m_cur+1); tag_q.push_back({tag, " R8 owned stat"});
        break;
      end
      chunk = (rem > BUFB) ? BUFB : rem;
      model[2*m_cur+1] = {16'h0, rem <= BUFB, first, 14'(chunk)};
      model[2*m_cur]   = model[2*m_cur] | 32'h1;
      exp_q.push_back(2*m_cur+1); tag_q.push_back({tag, " R3 R5 stat"});
      exp_q.push_back(2*m_cur);   tag_q.push_back({tag, " R4 addr"});
      if (model[2*m_cur][1] || m_cur == NDESC-1) m_cur = m_base;
      else m_cur = m_cur + 1;
      rem = rem - chunk;
      first = 1'b0;
    end while (rem > 0);

    @(negedge clk) begin frm_valid = 1'b1; frm_len = 14'(len); end
    @(negedge clk) begin frm_valid = 1'b0; frm_len = 14'h3FFF; end
    chk({tag, " R2 ready low after accept"}, {31'h0, frm_ready}, 32'h0);
    if (stall) begin
      sw_we = 1'b1; sw_addr = 6'd50; sw_wdata = 32'hABCD0000;
      model[50] = 32'hABCD0000;
      exp_q.push_back(50); tag_q.push_back({tag, " R10 sw word"});
      repeat (3) @(negedge clk);
      sw_we = 1'b0;
    end
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    chk({tag, " R8 nobuf count"}, 32'(nb_cnt), 32'(exp_nb));
    monitor_drain();
  endtask

  // monitor: pops expected entries and compares them with the store
  task automatic monitor_drain();
    logic [31:0] d;
    int a;
    string t;
    while (exp_q.size() > 0) begin
      a = exp_q.pop_front();
      t = tag_q.pop_front();
      rd(a, d);
      chk($sformatf("%s word %0d", t, a), d, model[a]);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 2*NDESC; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", {31'h0, frm_ready}, 32'h1);
    chk("R1 nobuf", {31'h0, nobuf}, 32'h0);
    rd(0, d);  chk("R1 word0", d, 32'h0);
    rd(1, d);  chk("R1 word1", d, 32'h0);
    rd(63, d); chk("R11 R1 word63", d, 32'h0);

    for (int i = 0; i < 4; i++) begin
      wr(2*i,   32'h1000 * (i + 1) | ((i == 3) ? 32'h2 : 32'h0));
      wr(2*i+1, 32'hF0000000);
    end
    send(64,   1'b0, "single R3");
    send(3000, 1'b0, "split R5");
    send(0,    1'b0, "zero-len wrap R6");
    send(100,  1'b0, "owned drop R8");

    wr(0, 32'h1000); wr(1, 32'hF0000000);
    wr(2, 32'h2000); wr(3, 32'hF0000000);
    send(5000, 1'b0, "mid-frame drop R8");
    wr(4, 32'h3000);
    send(10,   1'b0, "resume R8");

    setbase(8);
    send(200,  1'b0, "base R9");

    setbase(30);
    send(20,   1'b0, "last-1 R7");
    send(20,   1'b0, "last R7");
    wr(60, 32'h0);
    send(33,   1'b0, "back to base R7");

    setbase(12);
    send(77,   1'b1, "sw collision R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule